// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of acceleration samples and raises event pulses when it sees short, sharp excursions ("taps"). A sample counts as active when its magnitude is strictly greater than a programmable threshold. An excursion is a run of active samples. It qualifies as a tap only if it ends before a programmable maximum duration is reached. Every qualifying first excursion produces a single-tap pulse.

A double tap is a timed sequence that follows a qualifying first tap. The block first waits through a quiet latency interval, and then opens a window interval. A second qualifying excursion that starts inside the window produces a double-tap pulse. All time intervals are counted in accepted samples, meaning clock cycles on which the sample-valid strobe is high. Both pulses are single-cycle outputs meant for an interrupt controller.

Top module: `tap_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `single_tap` and `double_tap` are both 0.
- R2: A sample is active only when its absolute value (two's complement) is strictly greater than `thr_lvl`. A sample equal to the threshold is inactive. A negative sample is active by its magnitude.
- R3: A run of L consecutive active accepted samples, with 1 <= L < `dur_lim`, that is ended by an inactive accepted sample gives `single_tap` = 1 in the cycle after that ending sample is accepted.
- R4: A run with L >= `dur_lim` gives no pulse. The block then waits for an inactive sample and returns to looking for a first tap.
- R5: With `dur_lim` = 0, no pulse is ever produced.
- R6: Number the accepted samples after the end of a qualifying first tap as t = 1, 2, and so on. If samples 1..`lat_lim` are inactive, and a second excursion starts at a t in `lat_lim`+1 .. `lat_lim`+`win_lim` and qualifies as in R3, then `double_tap` = 1 in the cycle after its ending sample. No `single_tap` is produced for that second excursion.
- R7: An active sample at t <= `lat_lim` cancels the double-tap sequence. That excursion produces no pulse of either kind, and detection restarts after the next inactive sample.
- R8: If samples 1..`lat_lim`+`win_lim` are all inactive, the sequence ends. The next excursion is treated as a first tap.
- R9: With `lat_lim` = 0 or `win_lim` = 0, no double tap occurs, and every qualifying excursion gives a single tap.
- R10: Cycles with `smp_vld` = 0 have no effect: their sample is neither compared nor counted.
- R11: Each pulse lasts exactly one cycle, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp_data | input | SMP_W | Signed acceleration sample |
| thr_lvl | input | THR_W | Unsigned tap threshold (scaled by THR_SHIFT) |
| dur_lim | input | CNT_W | Maximum tap length in samples, 0 disables |
| lat_lim | input | CNT_W | Quiet latency after a first tap, in samples |
| win_lim | input | CNT_W | Window for the second tap start, in samples |
| single_tap | output | 1 | Single-tap event pulse |
| double_tap | output | 1 | Double-tap event pulse |

## Verification
Directed sequences probe the edges of the main function:
- runs of length `dur_lim`-1 and `dur_lim`, which separate a tap from an overlong excursion;
- a sample exactly at the threshold, and a negative sample above it, which separate a strict magnitude compare from a signed or non-strict one;
- second taps at t = `lat_lim`, `lat_lim`+1, `lat_lim`+`win_lim` and one sample later, which separate a correct latency and window from off-by-one variants.

Invalid-strobe cycles inserted inside runs and gaps show whether idle cycles are wrongly counted. Constrained random streams with mixed limits, including zero values, exercise state combinations that the directed cases do not reach.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_TAP1 = 3'd1,
      S_LONG = 3'd2,
      S_LAT  = 3'd3,
      S_WIN  = 3'd4,
      S_TAP2 = 3'd5
   } tap_state_e;

endpackage

// File: rtl/tap_mag_cmp.sv
module tap_mag_cmp #(
   parameter int SMP_W     = 16,
   parameter int THR_W     = 8,
   parameter int THR_SHIFT = 0,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic [SMP_W-1:0] smp,
   input  logic [THR_W-1:0] thr,
   output logic             above
);
   localparam int REF_W = THR_W + THR_SHIFT;

   if (REF_W > SMP_W) begin : g_bad_width
      $error("tap_mag_cmp: scaled threshold wider than sample");
   end

   logic [SMP_W-1:0] mag;
   logic [SMP_W-1:0] ref_v;

   if (SIGNED_IN) begin : g_abs
      // two's complement magnitude; the most negative value maps to 2^(W-1)
      assign mag = smp[SMP_W-1] ? ((~smp) + SMP_W'(1)) : smp;
   end else begin : g_raw
      assign mag = smp;
   end

   assign ref_v = SMP_W'(thr) << THR_SHIFT;
   assign above = (mag > ref_v);

endmodule

// File: rtl/tap_tick_cnt.sv
module tap_tick_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_one,
   input  logic             inc,
   input  logic [CNT_W-1:0] lim,
   output logic             hit
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("tap_tick_cnt: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   cnt_plus;

   assign cnt_plus = {1'b0, cnt_q} + (CNT_W+1)'(1);
   // true when the count after this increment reaches the limit
   assign hit = (cnt_plus >= {1'b0, lim});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_one ? CNT_W'(1) : '0;
      end else if (inc) begin
         cnt_q <= cnt_plus[CNT_W-1:0];
      end
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !inc) |=> $stable(cnt_q));

endmodule

// File: rtl/tap_seq_fsm.sv
module tap_seq_fsm
   import tap_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic             above,
   input  logic [CNT_W-1:0] dur_lim,
   input  logic [CNT_W-1:0] lat_lim,
   input  logic [CNT_W-1:0] win_lim,
   input  logic             hit,
   output logic             cnt_load,
   output logic             cnt_one,
   output logic             cnt_inc,
   output logic [CNT_W-1:0] cnt_lim,
   output logic             single_o,
   output logic             double_o
);
   tap_state_e st_q, st_n;
   logic       sgl_n, dbl_n;
   logic       tap_en, dbl_en, multi_ok;

   assign tap_en   = (dur_lim != '0);
   assign dbl_en   = (lat_lim != '0) && (win_lim != '0);
   assign multi_ok = (dur_lim > CNT_W'(1));

   always_comb begin
      unique case (st_q)
         S_LAT:   cnt_lim = lat_lim;
         S_WIN:   cnt_lim = win_lim;
         default: cnt_lim = dur_lim;
      endcase
   end

   always_comb begin
      st_n     = st_q;
      cnt_load = 1'b0;
      cnt_one  = 1'b0;
      cnt_inc  = 1'b0;
      sgl_n    = 1'b0;
      dbl_n    = 1'b0;
      if (vld) begin
         case (st_q)
            S_IDLE: begin
               if (tap_en && above) begin
                  if (multi_ok) begin
                     st_n     = S_TAP1;
                     cnt_load = 1'b1;
                     cnt_one  = 1'b1;
                  end else begin
                     st_n = S_LONG;
                  end
               end
            end
            S_TAP1, S_TAP2: begin
               if (above) begin
                  cnt_inc = 1'b1;
                  if (hit) st_n = S_LONG;
               end else if (st_q == S_TAP1) begin
                  sgl_n = 1'b1;
                  if (dbl_en) begin
                     st_n     = S_LAT;
                     cnt_load = 1'b1;
                  end else begin
                     st_n = S_IDLE;
                  end
               end else begin
                  dbl_n = 1'b1;
                  st_n  = S_IDLE;
               end
            end
            S_LONG: begin
               if (!above) st_n = S_IDLE;
            end
            S_LAT: begin
               if (above) begin
                  st_n = S_LONG;
               end else begin
                  cnt_inc = 1'b1;
                  if (hit) begin
                     st_n     = S_WIN;
                     cnt_load = 1'b1;
                  end
               end
            end
            S_WIN: begin
               if (above) begin
                  if (multi_ok) begin
                     st_n     = S_TAP2;
                     cnt_load = 1'b1;
                     cnt_one  = 1'b1;
                  end else begin
                     st_n = S_LONG;
                  end
               end else begin
                  cnt_inc = 1'b1;
                  if (hit) st_n = S_IDLE;
               end
            end
            default: st_n = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         single_o <= 1'b0;
         double_o <= 1'b0;
      end else begin
         st_q     <= st_n;
         single_o <= sgl_n;
         double_o <= dbl_n;
      end
   end

   // R11: pulses are one cycle wide and mutually exclusive
   p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (single_o || double_o) |=> !(single_o || double_o));
   p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(single_o && double_o));
   // R10: no state change without a valid sample
   p_idle_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> $stable(st_q));
   // R5: tap detection disabled keeps the sequencer idle
   p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_IDLE && dur_lim == '0) |=> (st_q == S_IDLE));
   // R7: activity during the latency cancels the sequence
   p_lat_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_LAT && vld && above) |=> (st_q == S_LONG));
   // R8: a quiet window that runs out returns to idle
   p_win_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WIN && vld && !above && hit) |=> (st_q == S_IDLE));
   // R6: a double pulse only follows a second excursion
   p_dbl_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(double_o) |-> ($past(st_q) == S_TAP2));

endmodule

// File: rtl/tap_detect.sv
module tap_detect
   import tap_pkg::*;
#(
   parameter int SMP_W     = 16,
   parameter int THR_W     = 8,
   parameter int THR_SHIFT = 0,
   parameter int CNT_W     = 8,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] smp_data,
   input  logic [THR_W-1:0] thr_lvl,
   input  logic [CNT_W-1:0] dur_lim,
   input  logic [CNT_W-1:0] lat_lim,
   input  logic [CNT_W-1:0] win_lim,
   output logic             single_tap,
   output logic             double_tap
);
   if (SMP_W < 2 || THR_W < 1) begin : g_bad_param
      $error("tap_detect: illegal sample or threshold width");
   end

   logic             above;
   logic             hit;
   logic             cnt_load, cnt_one, cnt_inc;
   logic [CNT_W-1:0] cnt_lim;

   tap_mag_cmp #(
      .SMP_W(SMP_W), .THR_W(THR_W), .THR_SHIFT(THR_SHIFT), .SIGNED_IN(SIGNED_IN)
   ) u_mag (
      .smp(smp_data), .thr(thr_lvl), .above(above)
   );

   tap_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_one(cnt_one),
      .inc(cnt_inc), .lim(cnt_lim), .hit(hit)
   );

   tap_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .vld(smp_vld), .above(above),
      .dur_lim(dur_lim), .lat_lim(lat_lim), .win_lim(win_lim), .hit(hit),
      .cnt_load(cnt_load), .cnt_one(cnt_one), .cnt_inc(cnt_inc),
      .cnt_lim(cnt_lim), .single_o(single_tap), .double_o(double_tap)
   );

endmodule

// File: tb/test_tap_detect.sv
`timescale 1ns/1ps
module test_tap_detect;
   localparam int SMP_W = 16;
   localparam int THR_W = 8;
   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             smp_vld = 1'b0;
   logic [SMP_W-1:0] smp_data = '0;
   logic [THR_W-1:0] thr_lvl = '0;
   logic [CNT_W-1:0] dur_lim = '0, lat_lim = '0, win_lim = '0;
   logic             single_tap, double_tap;

   int errs = 0, checks = 0;
   int thr = 50, dur = 4, lat = 2, win = 3;
   int m_st = 0, m_cnt = 0;
   bit exp_s = 0, exp_d = 0;
   int obs_s = 0, obs_d = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tap_detect i_tap_detect (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .thr_lvl(thr_lvl), .dur_lim(dur_lim), .lat_lim(lat_lim), .win_lim(win_lim),
      .single_tap(single_tap), .double_tap(double_tap)
   );

   function automatic bit is_above(int v, int t);
      int m = (v < 0) ? -v : v;
      return m > t;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected behaviour per accepted sample, from the requirements
   task automatic model_step(input bit v, input bit ab);
      exp_s = 0; exp_d = 0;
      if (!v) return;
      case (m_st)
         0: if (dur != 0 && ab) begin
               if (dur <= 1) m_st = 2; else begin m_st = 1; m_cnt = 1; end
            end
         1, 5: if (ab) begin
               m_cnt++;
               if (m_cnt >= dur) m_st = 2;
            end else if (m_st == 1) begin
               exp_s = 1;
               if (lat != 0 && win != 0) begin m_st = 3; m_cnt = 0; end
               else m_st = 0;
            end else begin
               exp_d = 1; m_st = 0;
            end
         2: if (!ab) m_st = 0;
         3: if (ab) m_st = 2;
            else begin
               m_cnt++;
               if (m_cnt >= lat) begin m_st = 4; m_cnt = 0; end
            end
         4: if (ab) begin
               if (dur <= 1) m_st = 2; else begin m_st = 5; m_cnt = 1; end
            end else begin
               m_cnt++;
               if (m_cnt >= win) m_st = 0;
            end
         default: m_st = 0;
      endcase
   endtask

   // called at a negedge; returns at the following negedge
   task automatic send(input bit v, input int val, input string tag);
      smp_vld  = v;
      smp_data = val[SMP_W-1:0];
      @(posedge clk);
      model_step(v, is_above(val, thr));
      @(negedge clk);
      check(single_tap == exp_s, tag, single_tap, exp_s);
      check(double_tap == exp_d, tag, double_tap, exp_d);
      check(!(single_tap && double_tap), "R11", 1, 0);
      obs_s += single_tap;
      obs_d += double_tap;
   endtask

   task automatic quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) send(1'b1, 0, tag);
   endtask

   task automatic setup(input int t, input int d, input int l, input int w);
      thr = t; dur = d; lat = l; win = w;
      thr_lvl = THR_W'(t); dur_lim = CNT_W'(d); lat_lim = CNT_W'(l); win_lim = CNT_W'(w);
      smp_vld = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      check(single_tap == 0 && double_tap == 0, "R1", single_tap + double_tap, 0);
      rst_n = 1;
      m_st = 0; m_cnt = 0;
      @(negedge clk);
      check(single_tap == 0 && double_tap == 0, "R1", single_tap + double_tap, 0);
      obs_s = 0; obs_d = 0;
   endtask

   initial begin
      void'($urandom(32'd7311));
      @(negedge clk);
      setup(50, 4, 2, 3);

      // R2: equal to threshold is inactive; negative magnitude counts
      send(1, 50, "R2"); send(1, 0, "R2");
      send(1, -50, "R2"); send(1, 0, "R2");
      send(1, -51, "R2"); send(1, 0, "R2");
      quiet(8, "R2");
      check(obs_s == 1 && obs_d == 0, "R2", obs_s, 1);

      // R3: run of dur-1 qualifies
      obs_s = 0; obs_d = 0;
      send(1, 90, "R3"); send(1, 120, "R3"); send(1, 60, "R3"); send(1, 3, "R3");
      quiet(8, "R3");
      check(obs_s == 1, "R3", obs_s, 1);

      // R4: run of dur is too long
      obs_s = 0; obs_d = 0;
      for (int i = 0; i < 4; i++) send(1, 200, "R4");
      send(1, 0, "R4"); quiet(8, "R4");
      check(obs_s == 0 && obs_d == 0, "R4", obs_s + obs_d, 0);

      // R6: second tap at t = lat+1
      obs_s = 0; obs_d = 0;
      send(1, 99, "R6"); send(1, 0, "R6");
      quiet(2, "R6");
      send(1, 99, "R6"); send(1, 0, "R6");
      quiet(8, "R6");
      check(obs_s == 1 && obs_d == 1, "R6", obs_d, 1);

      // R6: second tap at t = lat+win
      obs_s = 0; obs_d = 0;
      send(1, -99, "R6"); send(1, 0, "R6");
      quiet(4, "R6");
      send(1, 99, "R6"); send(1, 99, "R6"); send(1, 0, "R6");
      quiet(8, "R6");
      check(obs_d == 1, "R6", obs_d, 1);

      // R7: second tap at t = lat is too early
      obs_s = 0; obs_d = 0;
      send(1, 99, "R7"); send(1, 0, "R7");
      quiet(1, "R7");
      send(1, 99, "R7"); send(1, 0, "R7");
      quiet(8, "R7");
      check(obs_s == 1 && obs_d == 0, "R7", obs_s * 10 + obs_d, 10);

      // R8: start at t = lat+win+1 is a new first tap
      obs_s = 0; obs_d = 0;
      send(1, 99, "R8"); send(1, 0, "R8");
      quiet(5, "R8");
      send(1, 99, "R8"); send(1, 0, "R8");
      quiet(8, "R8");
      check(obs_s == 2 && obs_d == 0, "R8", obs_s * 10 + obs_d, 20);

      // R10: invalid cycles inside a run and a gap are ignored
      obs_s = 0; obs_d = 0;
      send(1, 99, "R10");
      for (int i = 0; i < 5; i++) send(0, 300, "R10");
      send(1, 99, "R10"); send(1, 0, "R10");
      for (int i = 0; i < 6; i++) send(0, 0, "R10");
      quiet(2, "R10");
      send(1, 99, "R10"); send(1, 0, "R10");
      quiet(8, "R10");
      check(obs_s == 1 && obs_d == 1, "R10", obs_s * 10 + obs_d, 11);

      // R5: duration zero disables everything
      setup(50, 0, 2, 3);
      send(1, 99, "R5"); send(1, 0, "R5"); quiet(2, "R5");
      send(1, 99, "R5"); send(1, 0, "R5"); quiet(4, "R5");
      check(obs_s == 0 && obs_d == 0, "R5", obs_s + obs_d, 0);

      // R9: latency zero disables double tap
      setup(50, 4, 0, 3);
      send(1, 99, "R9"); send(1, 0, "R9"); quiet(1, "R9");
      send(1, 99, "R9"); send(1, 0, "R9"); quiet(4, "R9");
      check(obs_s == 2 && obs_d == 0, "R9", obs_s * 10 + obs_d, 20);

      // random streams, compared against the model every sample (R3/R6/R11)
      for (int seg = 0; seg < 10; seg++) begin
         setup(20 + $urandom % 80, $urandom % 7, $urandom % 5, $urandom % 6);
         for (int n = 0; n < 500; n++) begin
            bit v = ($urandom % 4) != 0;
            int mag = (($urandom % 10) < 4) ? thr + 1 + $urandom % 50
                                            : $urandom % (thr + 1);
            int val = ($urandom % 2) ? -mag : mag;
            send(v, val, "R11");
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule